// File: doc/BRIEF.md
# Sampled Converter Conversion Sequencer

This block decides when an external data converter runs. It has two modes. In continuous mode it starts one conversion after another. In single-shot mode it stays powered down until the host asks for exactly one conversion. The host reaches the block through a two-address register port. One address returns the latest result. The other holds the mode bit and a combined start/status bit.

On the converter side, the block sends a one-cycle start pulse. It then waits for a done pulse that carries a wide signed raw value. That value is clamped to the 16-bit two's complement range and stored in the result register.

A host can run the block at a low effective sample rate to save power. It requests single-shot conversions at a fast converter setting, and the block powers down on its own between requests. A broadcast reset request from the bus side puts the block back into its power-up state.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After `rst_n` is released, the control word (address 1) reads 0x0003, the result (address 0) reads 0x0000, `pdown` is 1 and `cnv_start` is 0. In the control word, bit 0 is start/status (1 = idle) and bit 1 is mode (1 = single-shot, 0 = continuous).
- R2: A one-cycle `gc_reset` pulse restores the R1 state in the next cycle, even in the middle of a conversion.
- R3: In single-shot mode while idle, no `cnv_start` is issued until the host writes 1 to bit 0 of the control word.
- R4: From the cycle after a start is accepted until the result is stored, control bit 0 reads 0 and `pdown` is 0.
- R5: In single-shot mode, the cycle after `cnv_done` the result register holds the new value, control bit 0 reads 1 and `pdown` is 1.
- R6: Writing 1 to control bit 0 during a conversion neither restarts nor queues a conversion. Exactly one `cnv_start` is issued per single-shot request.
- R7: In continuous mode, `cnv_start` is high in the cycle right after each `cnv_done`, and each result is stored in that same cycle.
- R8: The stored result is `cnv_raw` clamped to the range 0x8000..0x7FFF. Raw values above 32767 give 0x7FFF, raw values below -32768 give 0x8000, and values in range pass through unchanged.
- R9: A write that sets mode to single-shot during a continuous conversion takes effect when that conversion completes. The result is stored, no further start follows, and the block powers down.
- R10: The result register keeps its value through any length of power-down.
- R11: A `cnv_done` pulse while no conversion is in progress changes neither the result nor the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| gc_reset | input | 1 | Synchronous broadcast reset request, one-cycle pulse |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 1 | 0 = result, 1 = control |
| reg_wdata | input | 2 | Write data for the control word (bit 0 start, bit 1 mode) |
| reg_rdata | output | 16 | Read data for the selected address |
| cnv_start | output | 1 | One-cycle conversion start pulse |
| cnv_done | input | 1 | Converter completion pulse |
| cnv_raw | input | RAW_W | Signed raw converter value, valid with `cnv_done` |
| pdown | output | 1 | Power-down flag for the converter |

## Verification
Single-shot requests use directed raw values on both sides of each clamp boundary (32767/32768, -32768/-32769, the widest raw extremes) plus random wide values. This separates clamping from plain truncation of the raw value. One request carries an extra start write in the middle of the conversion, which shows whether a second start is ignored or wrongly queued. Continuous runs with random raw values check the back-to-back start timing. A long idle period and a spurious done pulse show that power-down keeps the result. A mode switch and a broadcast reset, each made during a conversion, separate a mode change that waits for the conversion to finish from a reset that takes effect at once.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int CTRL_W        = 2;
    localparam int CTRL_STAT_BIT = 0;
    localparam int CTRL_MODE_BIT = 1;
    localparam logic ADDR_RESULT = 1'b0;
    localparam logic ADDR_CTRL   = 1'b1;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_CONV = 1'b1
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       mode_single;
        logic       start;
        logic       pdown;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RST = '{state: SQ_IDLE, mode_single: 1'b1,
                                      start: 1'b0, pdown: 1'b1};
endpackage

// File: rtl/adc_seq_sat.sv
module adc_seq_sat #(
    parameter int RAW_W = 20,
    parameter int OUT_W = 16
) (
    input  logic signed [RAW_W-1:0] raw,
    output logic        [OUT_W-1:0] clamped
);
    localparam logic signed [RAW_W-1:0] POS_LIM = RAW_W'((64'sd1 <<< (OUT_W-1)) - 1);
    localparam logic signed [RAW_W-1:0] NEG_LIM = -RAW_W'(64'sd1 <<< (OUT_W-1));
    localparam logic [OUT_W-1:0] POS_CODE = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_CODE = {1'b1, {(OUT_W-1){1'b0}}};

    generate
        if (RAW_W > OUT_W) begin : g_clamp
            always_comb begin
                if (raw > POS_LIM)      clamped = POS_CODE;
                else if (raw < NEG_LIM) clamped = NEG_CODE;
                else                    clamped = raw[OUT_W-1:0];
            end
        end else begin : g_pass
            assign clamped = OUT_W'(raw);
        end
    endgenerate
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic wr_ctrl,
    input  logic wr_start,
    input  logic wr_mode,
    input  logic cnv_done,
    output logic cnv_start,
    output logic store_en,
    output logic busy,
    output logic pdown,
    output logic mode_single
);
    seq_regs_t q, d;
    logic mode_eff;

    always_comb begin
        d        = q;
        d.start  = 1'b0;
        mode_eff = wr_ctrl ? wr_mode : q.mode_single;
        store_en = 1'b0;
        if (wr_ctrl) d.mode_single = wr_mode;
        case (q.state)
            SQ_IDLE: begin
                d.pdown = 1'b1;
                if (!mode_eff || (wr_ctrl && wr_start)) begin
                    d.state = SQ_CONV;
                    d.start = 1'b1;
                    d.pdown = 1'b0;
                end
            end
            SQ_CONV: begin
                if (cnv_done) begin
                    store_en = 1'b1;
                    if (mode_eff) begin
                        d.state = SQ_IDLE;
                        d.pdown = 1'b1;
                    end else begin
                        d.start = 1'b1;
                    end
                end
            end
            default: d = SEQ_RST;
        endcase
        if (soft_rst) begin
            d        = SEQ_RST;
            store_en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    assign cnv_start   = q.start;
    assign busy        = (q.state == SQ_CONV);
    assign pdown       = q.pdown;
    assign mode_single = q.mode_single;

    a_r2_gc_restores: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (q.state == SQ_IDLE) && q.mode_single && q.pdown && !q.start);

    a_r3_idle_waits: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (q.state == SQ_IDLE) && q.mode_single && !wr_ctrl |=> !q.start);

    a_r4_awake_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == SQ_CONV) |-> !q.pdown);

    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (q.state == SQ_CONV) && !cnv_done |=> !q.start && (q.state == SQ_CONV));

    a_r7_back_to_back: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (q.state == SQ_CONV) && cnv_done && !mode_eff |=> q.start && (q.state == SQ_CONV));

    a_r5_single_sleep: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (q.state == SQ_CONV) && cnv_done && mode_eff |=> (q.state == SQ_IDLE) && q.pdown);
endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             store_en,
    input  logic [OUT_W-1:0] din,
    output logic [OUT_W-1:0] dout
);
    logic [OUT_W-1:0] res_d, res_q;

    always_comb begin
        res_d = res_q;
        if (store_en) res_d = din;
        if (soft_rst) res_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign dout = res_q;

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        !store_en |=> $stable(res_q));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RAW_W = 20,
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    gc_reset,
    input  logic                    reg_wr,
    input  logic                    reg_addr,
    input  logic [CTRL_W-1:0]       reg_wdata,
    output logic [OUT_W-1:0]        reg_rdata,
    output logic                    cnv_start,
    input  logic                    cnv_done,
    input  logic signed [RAW_W-1:0] cnv_raw,
    output logic                    pdown
);
    logic             wr_ctrl, store_en, busy, mode_single;
    logic [OUT_W-1:0] clamped, result;

    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);

    adc_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (gc_reset),
        .wr_ctrl    (wr_ctrl),
        .wr_start   (reg_wdata[CTRL_STAT_BIT]),
        .wr_mode    (reg_wdata[CTRL_MODE_BIT]),
        .cnv_done   (cnv_done),
        .cnv_start  (cnv_start),
        .store_en   (store_en),
        .busy       (busy),
        .pdown      (pdown),
        .mode_single(mode_single)
    );

    adc_seq_sat #(.RAW_W(RAW_W), .OUT_W(OUT_W)) u_sat (
        .raw    (cnv_raw),
        .clamped(clamped)
    );

    adc_seq_result #(.OUT_W(OUT_W)) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(gc_reset),
        .store_en(store_en),
        .din     (clamped),
        .dout    (result)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTRL) begin
            reg_rdata[CTRL_STAT_BIT] = !busy;
            reg_rdata[CTRL_MODE_BIT] = mode_single;
        end else begin
            reg_rdata = result;
        end
    end

    a_r8_sign_kept: assert property (@(posedge clk) disable iff (!rst_n || gc_reset)
        store_en |=> result[OUT_W-1] == $past(cnv_raw[RAW_W-1]));

    a_r11_stray_done: assert property (@(posedge clk) disable iff (!rst_n || gc_reset)
        !busy && cnv_done && !reg_wr |=> $stable(result));
endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
    localparam int RAW_W = 20;
    localparam int LAT   = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gc_reset = 1'b0;
    logic reg_wr = 1'b0;
    logic reg_addr = 1'b0;
    logic [1:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic cnv_start, cnv_done, pdown;
    logic signed [RAW_W-1:0] cnv_raw;

    logic mdl_done = 1'b0;
    logic spur_done = 1'b0;
    logic signed [RAW_W-1:0] raw_hold = '0;
    logic signed [RAW_W-1:0] pending = '0;
    int cnt = 0;
    int nstart = 0;
    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [15:0] exp_res = '0;

    always #10 clk = ~clk;

    assign cnv_done = mdl_done | spur_done;
    assign cnv_raw  = raw_hold;

    adc_seq_ctrl #(.RAW_W(RAW_W), .OUT_W(16)) u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .gc_reset(gc_reset), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cnv_start(cnv_start), .cnv_done(cnv_done), .cnv_raw(cnv_raw), .pdown(pdown)
    );

    // converter model with fixed latency
    always @(posedge clk) begin
        if (cnv_start) begin
            cnt      <= LAT;
            raw_hold <= pending;
            nstart   <= nstart + 1;
        end else if (cnt != 0) begin
            cnt <= cnt - 1;
        end
        mdl_done <= !cnv_start && (cnt == 1);
    end

    function automatic logic [15:0] sat16(input logic signed [RAW_W-1:0] v);
        if (v > 32767)       return 16'h7FFF;
        else if (v < -32768) return 16'h8000;
        else                 return v[15:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic rd(input logic a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr_ctl(input logic st, input logic md);
        reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = {md, st};
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic wait_done();
        for (int g = 0; g < 1000 && !cnv_done; g++) @(negedge clk);
    endtask

    task automatic set_next(input logic signed [RAW_W-1:0] v);
        pending = v;
        exp_res = sat16(v);
    endtask

    task automatic single_shot(input logic signed [RAW_W-1:0] v, input bit extra_wr);
        logic [15:0] r;
        int s0;
        s0 = nstart;
        wr_ctl(1'b1, 1'b1);
        set_next(v);
        rd(1'b1, r);
        chk(r[0] == 1'b0 && pdown == 1'b0, "R4 busy status", {r[0], pdown}, 0);
        if (extra_wr) begin
            repeat (3) @(negedge clk);
            wr_ctl(1'b1, 1'b1);
            rd(1'b1, r);
            chk(r[0] == 1'b0, "R6 still busy after extra start", r[0], 0);
        end
        wait_done();
        @(negedge clk);
        rd(1'b0, r);
        chk(r == exp_res, "R8 clamped result", r, exp_res);
        rd(1'b1, r);
        chk(r[0] == 1'b1 && pdown == 1'b1, "R5 idle and powered down", {r[0], pdown}, 3);
        repeat (LAT + 4) @(negedge clk);
        chk(nstart - s0 == 1, "R6 one start per request", nstart - s0, 1);
    endtask

    initial begin
        logic [15:0] r;
        int s0;
        logic signed [RAW_W-1:0] dir [8];
        void'($urandom(32'd4242));
        dir[0] = 100;       dir[1] = 32767;     dir[2] = 32768;   dir[3] = -32768;
        dir[4] = -32769;    dir[5] = 20'h7FFFF; dir[6] = 20'h80000; dir[7] = -1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(1'b1, r); chk(r == 16'h0003, "R1 control word", r, 3);
        rd(1'b0, r); chk(r == 16'h0000, "R1 result", r, 0);
        chk(pdown == 1'b1 && cnv_start == 1'b0, "R1 pdown/start", {pdown, cnv_start}, 2);

        repeat (40) @(negedge clk);
        chk(nstart == 0, "R3 no start while idle", nstart, 0);

        for (int i = 0; i < 8; i++) single_shot(dir[i], i == 2);
        for (int i = 0; i < 8; i++) single_shot(RAW_W'($urandom), 1'b0);

        // long power-down (duty-cycled operation)
        s0 = nstart;
        repeat (300) @(negedge clk);
        rd(1'b0, r); chk(r == exp_res, "R10 result retained", r, exp_res);
        chk(pdown == 1'b1 && nstart == s0, "R3 stays asleep", {pdown, 1'b0}, 2);

        spur_done = 1'b1; @(negedge clk); spur_done = 1'b0;
        repeat (3) @(negedge clk);
        rd(1'b0, r); chk(r == exp_res, "R11 stray done ignored", r, exp_res);
        rd(1'b1, r); chk(r == 16'h0003 && nstart == s0, "R11 state unchanged", r, 3);

        // continuous mode
        wr_ctl(1'b0, 1'b0);
        set_next(RAW_W'($urandom));
        for (int i = 0; i < 10; i++) begin
            wait_done();
            @(negedge clk);
            chk(cnv_start == 1'b1, "R7 start right after done", cnv_start, 1);
            rd(1'b0, r); chk(r == exp_res, "R7 result stored", r, exp_res);
            rd(1'b1, r); chk(r[0] == 1'b0, "R4 busy in continuous", r[0], 0);
            set_next(RAW_W'($urandom));
        end

        // switch back to single-shot mid conversion
        repeat (2) @(negedge clk);
        wr_ctl(1'b0, 1'b1);
        rd(1'b1, r); chk(r[0] == 1'b0, "R9 conversion continues", r[0], 0);
        wait_done();
        @(negedge clk);
        chk(cnv_start == 1'b0, "R9 no further start", cnv_start, 0);
        rd(1'b0, r); chk(r == exp_res, "R9 final result stored", r, exp_res);
        rd(1'b1, r); chk(r == 16'h0003 && pdown == 1'b1, "R9 powered down", r, 3);
        s0 = nstart;
        repeat (50) @(negedge clk);
        chk(nstart == s0, "R9 stays stopped", nstart - s0, 0);

        // broadcast reset during a conversion
        wr_ctl(1'b0, 1'b0);
        set_next(20'sd1234);
        repeat (3) @(negedge clk);
        gc_reset = 1'b1; @(negedge clk); gc_reset = 1'b0;
        rd(1'b1, r); chk(r == 16'h0003, "R2 control word", r, 3);
        rd(1'b0, r); chk(r == 16'h0000, "R2 result cleared", r, 0);
        chk(pdown == 1'b1 && cnv_start == 1'b0, "R2 pdown/start", {pdown, cnv_start}, 2);
        s0 = nstart;
        repeat (LAT + 5) @(negedge clk);
        rd(1'b0, r); chk(r == 16'h0000, "R11 late done after reset ignored", r, 0);
        chk(nstart == s0, "R2 no start after reset", nstart - s0, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule